// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block decides when a microcontroller may stop its main clocks and when and how they come back. A sleep request from one of the run modes goes to a clock-stopped watch state only if three configuration inputs agree. In every other case the request goes to an ordinary sleep state, where the CPU halts but the peripherals keep running. In watch state only the low-speed watchdog keeps its clock. A group of wake inputs is filtered by per-line enables and the CPU interrupt mask. On a qualifying wake the block chooses a destination run mode from flags it stored when it accepted the request.

A return to the fast clock first switches the clocks back on. It then waits a settling time, chosen by a 3-bit field, before it raises a one-cycle interrupt-start pulse. An external reset pin and a standby pin override the normal sequence. The standby pin forces a fully gated standby state. The reset pin turns all clocks on and starts reset handling after both the pin is released and the settling time has run out. The outputs are a one-hot mode vector, three clock enables and two start pulses.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the mode is high-speed (`mode_oh` = 8'h01), all three clock enables are 1, and `irq_start` and `rst_exc_start` are 0.
- R2: A one-cycle `sleep_req` in high-speed, medium-speed or subactive mode moves the block to watch mode (bit 4) on the next edge when `cfg_stby_en`=1, `cfg_direct_xfer`=0 and `cfg_wdt_sel`=1. For any other combination of those three inputs it moves to sleep mode (bit 3).
- R3: The clock enables (cpu, periph, wdt) are 1,1,1 in the run modes, in settling and in reset-hold. They are 0,1,1 in sleep, 0,0,1 in watch and 0,0,0 in hardware standby.
- R4: In watch or sleep mode, an IRQ, key-input or wake-event line, or the watchdog overflow, wakes the block only when its own enable is 1 and `cpu_mask` is 0. `nmi` wakes it regardless of the mask.
- R5: On a wake from watch mode with the captured low-speed flag set, the block enters subactive mode (bit 2) on the next edge, and `irq_start` is 1 for that first cycle.
- R6: On a wake from watch mode with the low-speed flag clear, the block stays in settling mode (bit 5) for exactly 2^(SETTLE_BASE+sel) cycles, where sel is `cfg_settle_sel` at the wake. It then enters medium-speed mode (bit 1) if the captured divider flag is 1, and high-speed mode (bit 0) otherwise. `irq_start` is high only in that first cycle.
- R7: A qualified wake in sleep mode returns the block to the run mode it came from, with a one-cycle `irq_start`.
- R8: `pin_reset_n` low moves the block to reset-hold mode (bit 6) on the next edge from any state except hardware standby, and all clocks are enabled there. Reset-hold ends, with a one-cycle `rst_exc_start` in the first high-speed cycle, at the first edge where the pin is high and at least 2^(SETTLE_BASE+sel) reset-hold cycles have passed.
- R9: `pin_standby_n` low forces hardware standby (bit 7) on the next edge from any state, and takes priority over the reset pin and all wakes. When the pin is released, the block enters reset-hold and follows R8.
- R10: `sleep_req` has no effect outside the three run modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| cfg_stby_en | input | 1 | Standby-enable configuration bit |
| cfg_direct_xfer | input | 1 | Direct-transfer configuration bit |
| cfg_wdt_sel | input | 1 | Watchdog clock-select configuration bit |
| cfg_low_speed | input | 1 | Wake into subactive mode when 1 |
| cfg_med_div | input | 1 | Wake into medium-speed instead of high-speed when 1 |
| cfg_settle_sel | input | SEL_W | Settling-time select |
| cpu_mask | input | 1 | CPU interrupt mask, 1 = masked |
| nmi | input | 1 | Non-maskable wake |
| wdt_ovf | input | 1 | Low-speed watchdog overflow |
| wdt_ovf_ie | input | 1 | Enable for watchdog overflow wake |
| irq_lines | input | NIRQ | External interrupt lines |
| irq_en | input | NIRQ | Per-line IRQ enables |
| key_lines | input | NKEY | Key-input lines |
| key_en | input | NKEY | Per-line key-input enables |
| wue_lines | input | NWUE | Wake-event lines |
| wue_en | input | NWUE | Per-line wake-event enables |
| pin_reset_n | input | 1 | Reset pin, active low |
| pin_standby_n | input | 1 | Standby pin, active low |
| mode_oh | output | 8 | One-hot mode: 0 high, 1 medium, 2 subactive, 3 sleep, 4 watch, 5 settling, 6 reset-hold, 7 hardware standby |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_periph | output | 1 | Peripheral clock enable |
| clk_en_wdt | output | 1 | Low-speed watchdog clock enable |
| irq_start | output | 1 | One-cycle pulse: interrupt handling may begin |
| rst_exc_start | output | 1 | One-cycle pulse: reset handling may begin |

## Verification
The assertions assume that every input is synchronous to `clk` and that `sleep_req` is a single-cycle pulse. They also assume the configuration inputs are stable in the cycle a request or wake is taken, because the flags and the settling select are captured at that edge. The bench changes inputs only just after falling edges and holds each request for exactly one cycle. It changes configuration only while no request or wake is pending, and it clears every wake line before the next sleep request, so each sweep starts from a known mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int unsigned MODE_W = 8;

    typedef enum logic [2:0] {
        M_HIGH    = 3'd0,
        M_MED     = 3'd1,
        M_SUB     = 3'd2,
        M_SLEEP   = 3'd3,
        M_WATCH   = 3'd4,
        M_SETTLE  = 3'd5,
        M_RSTHOLD = 3'd6,
        M_HWSTBY  = 3'd7
    } lpm_mode_e;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic wdt;
    } clk_en_t;

    // Clock gating per mode
    function automatic clk_en_t clocks_for(lpm_mode_e m);
        clk_en_t c;
        case (m)
            M_SLEEP:  c = '{cpu: 1'b0, periph: 1'b1, wdt: 1'b1};
            M_WATCH:  c = '{cpu: 1'b0, periph: 1'b0, wdt: 1'b1};
            M_HWSTBY: c = '{cpu: 1'b0, periph: 1'b0, wdt: 1'b0};
            default:  c = '{cpu: 1'b1, periph: 1'b1, wdt: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NIRQ = 16,
    parameter int NKEY = 16,
    parameter int NWUE = 8
) (
    input  logic            cpu_mask,
    input  logic            nmi,
    input  logic            wdt_ovf,
    input  logic            wdt_ovf_ie,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NKEY-1:0] key_lines,
    input  logic [NKEY-1:0] key_en,
    input  logic [NWUE-1:0] wue_lines,
    input  logic [NWUE-1:0] wue_en,
    output logic            wake
);

    logic [NIRQ-1:0] irq_hit;
    logic [NKEY-1:0] key_hit;
    logic [NWUE-1:0] wue_hit;
    logic            maskable;

    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
        assign irq_hit[gi] = irq_lines[gi] & irq_en[gi];
    end
    for (genvar gk = 0; gk < NKEY; gk++) begin : g_key
        assign key_hit[gk] = key_lines[gk] & key_en[gk];
    end
    for (genvar gw = 0; gw < NWUE; gw++) begin : g_wue
        assign wue_hit[gw] = wue_lines[gw] & wue_en[gw];
    end

    always_comb begin
        maskable = (|irq_hit) | (|key_hit) | (|wue_hit) | (wdt_ovf & wdt_ovf_ie);
        wake     = nmi | (maskable & ~cpu_mask);
    end

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int SETTLE_BASE = 8,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             zero
);

    localparam int CNT_W = SETTLE_BASE + (2 ** SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = CNT_W'((32'd1 << (SETTLE_BASE + 32'(sel))) - 32'd1);
        end else if (run && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero = (tmr_q.cnt == '0);

    // R6: a running count falls by exactly one per cycle
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int NIRQ        = 16,
    parameter int NKEY        = 16,
    parameter int NWUE        = 8,
    parameter int SETTLE_BASE = 8,
    parameter int SEL_W       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               cfg_stby_en,
    input  logic               cfg_direct_xfer,
    input  logic               cfg_wdt_sel,
    input  logic               cfg_low_speed,
    input  logic               cfg_med_div,
    input  logic [SEL_W-1:0]   cfg_settle_sel,
    input  logic               cpu_mask,
    input  logic               nmi,
    input  logic               wdt_ovf,
    input  logic               wdt_ovf_ie,
    input  logic [NIRQ-1:0]    irq_lines,
    input  logic [NIRQ-1:0]    irq_en,
    input  logic [NKEY-1:0]    key_lines,
    input  logic [NKEY-1:0]    key_en,
    input  logic [NWUE-1:0]    wue_lines,
    input  logic [NWUE-1:0]    wue_en,
    input  logic               pin_reset_n,
    input  logic               pin_standby_n,
    output logic [MODE_W-1:0]  mode_oh,
    output logic               clk_en_cpu,
    output logic               clk_en_periph,
    output logic               clk_en_wdt,
    output logic               irq_start,
    output logic               rst_exc_start
);

    typedef struct packed {
        lpm_mode_e mode;
        logic      lson;
        logic      div;
        lpm_mode_e origin;
        clk_en_t   clk;
        logic      irq_start;
        logic      rst_exc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic wake;
    logic tmr_load;
    logic tmr_run;
    logic tmr_zero;
    logic watch_ok;
    logic in_run;

    lpm_wake_qual #(
        .NIRQ (NIRQ),
        .NKEY (NKEY),
        .NWUE (NWUE)
    ) i_wake (
        .cpu_mask   (cpu_mask),
        .nmi        (nmi),
        .wdt_ovf    (wdt_ovf),
        .wdt_ovf_ie (wdt_ovf_ie),
        .irq_lines  (irq_lines),
        .irq_en     (irq_en),
        .key_lines  (key_lines),
        .key_en     (key_en),
        .wue_lines  (wue_lines),
        .wue_en     (wue_en),
        .wake       (wake)
    );

    lpm_settle_timer #(
        .SETTLE_BASE (SETTLE_BASE),
        .SEL_W       (SEL_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (cfg_settle_sel),
        .run   (tmr_run),
        .zero  (tmr_zero)
    );

    always_comb begin
        watch_ok = cfg_stby_en & ~cfg_direct_xfer & cfg_wdt_sel;
        in_run   = (seq_q.mode == M_HIGH) || (seq_q.mode == M_MED) || (seq_q.mode == M_SUB);
    end

    always_comb begin
        seq_d           = seq_q;
        seq_d.irq_start = 1'b0;
        seq_d.rst_exc   = 1'b0;
        tmr_load        = 1'b0;
        tmr_run         = 1'b0;

        if (!pin_standby_n) begin
            seq_d.mode = M_HWSTBY;
        end else if (!pin_reset_n && (seq_q.mode != M_RSTHOLD)) begin
            seq_d.mode = M_RSTHOLD;
            tmr_load   = 1'b1;
        end else begin
            case (seq_q.mode)
                M_HIGH, M_MED, M_SUB: begin
                    if (sleep_req) begin
                        if (watch_ok) begin
                            seq_d.mode = M_WATCH;
                            seq_d.lson = cfg_low_speed;
                            seq_d.div  = cfg_med_div;
                        end else begin
                            seq_d.mode   = M_SLEEP;
                            seq_d.origin = seq_q.mode;
                        end
                    end
                end
                M_SLEEP: begin
                    if (wake) begin
                        seq_d.mode      = seq_q.origin;
                        seq_d.irq_start = 1'b1;
                    end
                end
                M_WATCH: begin
                    if (wake) begin
                        if (seq_q.lson) begin
                            seq_d.mode      = M_SUB;
                            seq_d.irq_start = 1'b1;
                        end else begin
                            seq_d.mode = M_SETTLE;
                            tmr_load   = 1'b1;
                        end
                    end
                end
                M_SETTLE: begin
                    tmr_run = 1'b1;
                    if (tmr_zero) begin
                        seq_d.mode      = seq_q.div ? M_MED : M_HIGH;
                        seq_d.irq_start = 1'b1;
                    end
                end
                M_RSTHOLD: begin
                    tmr_run = 1'b1;
                    if (pin_reset_n && tmr_zero) begin
                        seq_d.mode    = M_HIGH;
                        seq_d.rst_exc = 1'b1;
                    end
                end
                M_HWSTBY: begin
                    seq_d.mode = M_RSTHOLD;
                    tmr_load   = 1'b1;
                end
                default: seq_d.mode = M_HIGH;
            endcase
        end

        seq_d.clk = clocks_for(seq_d.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.mode      <= M_HIGH;
            seq_q.lson      <= 1'b0;
            seq_q.div       <= 1'b0;
            seq_q.origin    <= M_HIGH;
            seq_q.clk       <= '{cpu: 1'b1, periph: 1'b1, wdt: 1'b1};
            seq_q.irq_start <= 1'b0;
            seq_q.rst_exc   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode_oh       = MODE_W'(1) << seq_q.mode;
    assign clk_en_cpu    = seq_q.clk.cpu;
    assign clk_en_periph = seq_q.clk.periph;
    assign clk_en_wdt    = seq_q.clk.wdt;
    assign irq_start     = seq_q.irq_start;
    assign rst_exc_start = seq_q.rst_exc;

    // R9: standby pin wins and gates every clock
    a_r9_standby_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_standby_n |=> (seq_q.mode == M_HWSTBY) && !clk_en_cpu && !clk_en_periph && !clk_en_wdt);

    // R8: reset pin enters reset-hold with all clocks running
    a_r8_reset_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_standby_n && !pin_reset_n) |=> (seq_q.mode == M_RSTHOLD) && clk_en_cpu && clk_en_periph);

    // R2: a request with a wrong configuration never reaches watch mode
    a_r2_bad_cfg_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_standby_n && pin_reset_n && in_run && sleep_req && !watch_ok) |=> (seq_q.mode == M_SLEEP));

    // R3: in watch mode only the watchdog keeps its clock
    a_r3_watch_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode == M_WATCH) |-> (!clk_en_cpu && !clk_en_periph && clk_en_wdt));

    // R4: a masked CPU without NMI stays in watch mode
    a_r4_masked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_standby_n && pin_reset_n && seq_q.mode == M_WATCH && cpu_mask && !nmi) |=> (seq_q.mode == M_WATCH));

    // R6: the interrupt-start pulse lasts one cycle
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |=> !irq_start);

    // R10: a request during settling does not change the path
    a_r10_settle_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_standby_n && pin_reset_n && seq_q.mode == M_SETTLE && !tmr_zero) |=> (seq_q.mode == M_SETTLE));

endmodule

// File: tb/test_lpm_seq.sv
`timescale 1ns/1ps
module test_lpm_seq;

    localparam int NIRQ = 16;
    localparam int NKEY = 16;
    localparam int NWUE = 8;
    localparam int BASE = 2;
    localparam int SELW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sleep_req;
    logic            cfg_stby_en, cfg_direct_xfer, cfg_wdt_sel;
    logic            cfg_low_speed, cfg_med_div;
    logic [SELW-1:0] cfg_settle_sel;
    logic            cpu_mask, nmi, wdt_ovf, wdt_ovf_ie;
    logic [NIRQ-1:0] irq_lines, irq_en;
    logic [NKEY-1:0] key_lines, key_en;
    logic [NWUE-1:0] wue_lines, wue_en;
    logic            pin_reset_n, pin_standby_n;
    logic [7:0]      mode_oh;
    logic            clk_en_cpu, clk_en_periph, clk_en_wdt;
    logic            irq_start, rst_exc_start;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lpm_seq #(
        .NIRQ (NIRQ), .NKEY (NKEY), .NWUE (NWUE),
        .SETTLE_BASE (BASE), .SEL_W (SELW)
    ) i_lpm_seq (
        .clk (clk), .rst_n (rst_n), .sleep_req (sleep_req),
        .cfg_stby_en (cfg_stby_en), .cfg_direct_xfer (cfg_direct_xfer),
        .cfg_wdt_sel (cfg_wdt_sel), .cfg_low_speed (cfg_low_speed),
        .cfg_med_div (cfg_med_div), .cfg_settle_sel (cfg_settle_sel),
        .cpu_mask (cpu_mask), .nmi (nmi), .wdt_ovf (wdt_ovf), .wdt_ovf_ie (wdt_ovf_ie),
        .irq_lines (irq_lines), .irq_en (irq_en), .key_lines (key_lines), .key_en (key_en),
        .wue_lines (wue_lines), .wue_en (wue_en),
        .pin_reset_n (pin_reset_n), .pin_standby_n (pin_standby_n),
        .mode_oh (mode_oh), .clk_en_cpu (clk_en_cpu), .clk_en_periph (clk_en_periph),
        .clk_en_wdt (clk_en_wdt), .irq_start (irq_start), .rst_exc_start (rst_exc_start)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_mode(string tag, int idx);
        check(mode_oh == 8'(1 << idx), tag, 32'(mode_oh), 32'(1 << idx));
    endtask

    task automatic check_clk(string tag, logic [2:0] exp);
        check({clk_en_cpu, clk_en_periph, clk_en_wdt} == exp, tag,
              32'({clk_en_cpu, clk_en_periph, clk_en_wdt}), 32'(exp));
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic cfg_good();
        cfg_stby_en = 1'b1; cfg_direct_xfer = 1'b0; cfg_wdt_sel = 1'b1;
    endtask

    task automatic go_watch(bit ls, bit dv);
        cfg_good();
        cfg_low_speed = ls; cfg_med_div = dv;
        sleep_req = 1'b1;
        nx();
        sleep_req = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi = 1'b1;
        nx();
        nmi = 1'b0;
    endtask

    // counts cycles spent in mode idx, the current cycle included
    task automatic count_in(int idx, output int cnt);
        cnt = 1;
        for (int k = 0; k < 5000; k++) begin
            nx();
            if (!mode_oh[idx]) break;
            cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0; sleep_req = 1'b0;
        cfg_good(); cfg_low_speed = 1'b0; cfg_med_div = 1'b0; cfg_settle_sel = '0;
        cpu_mask = 1'b0; nmi = 1'b0; wdt_ovf = 1'b0; wdt_ovf_ie = 1'b0;
        irq_lines = '0; irq_en = '0; key_lines = '0; key_en = '0; wue_lines = '0; wue_en = '0;
        pin_reset_n = 1'b1; pin_standby_n = 1'b1;

        // R1 reset state
        repeat (3) nx();
        check_mode("R1 mode in reset", 0);
        check_clk("R1 clocks in reset", 3'b111);
        check(!irq_start && !rst_exc_start, "R1 pulses in reset", 32'({irq_start, rst_exc_start}), 0);
        rst_n = 1'b1;
        nx();
        check_mode("R1 mode after reset", 0);

        // R2 sweep of the three entry bits, R3 clocks, R7 return
        for (int c = 0; c < 8; c++) begin
            cfg_stby_en = c[2]; cfg_direct_xfer = c[1]; cfg_wdt_sel = c[0];
            cfg_low_speed = 1'b0; cfg_med_div = 1'b0; cfg_settle_sel = '0;
            sleep_req = 1'b1;
            nx();
            sleep_req = 1'b0;
            if (c == 5) begin
                check_mode("R2 entry to watch", 4);
                check_clk("R3 watch clocks", 3'b001);
                nmi_pulse();
                check_mode("R6 settling after wake", 5);
                check_clk("R3 settle clocks", 3'b111);
                count_in(5, cnt);
                check_mode("R6 back to high", 0);
            end else begin
                check_mode("R2 entry to sleep", 3);
                check_clk("R3 sleep clocks", 3'b011);
                irq_lines = 16'h0008; irq_en = 16'h0008;
                nx();
                irq_lines = '0; irq_en = '0;
                check_mode("R7 sleep returns to high", 0);
                check(irq_start, "R7 irq_start after sleep", 32'(irq_start), 1);
            end
        end
        cfg_good();

        // R5 low-speed destination, R7 from subactive
        go_watch(1'b1, 1'b0);
        check_mode("R5 watch", 4);
        nmi_pulse();
        check_mode("R5 wake to subactive", 2);
        check(irq_start, "R5 irq_start", 32'(irq_start), 1);
        check_clk("R3 subactive clocks", 3'b111);
        cfg_direct_xfer = 1'b1;
        sleep_req = 1'b1;
        nx();
        sleep_req = 1'b0;
        check_mode("R7 sub to sleep", 3);
        key_lines = 16'h8000; key_en = 16'h8000;
        nx();
        key_lines = '0; key_en = '0;
        check_mode("R7 sleep returns to subactive", 2);
        cfg_good();

        // R4 sweep: every line, every enable/mask pair
        for (int g = 0; g < 4; g++) begin
            int nl;
            nl = (g == 0) ? NIRQ : (g == 1) ? NKEY : (g == 2) ? NWUE : 1;
            for (int ln = 0; ln < nl; ln++) begin
                for (int em = 0; em < 4; em++) begin
                    bit woke;
                    go_watch(1'b1, 1'b0);
                    woke = em[1] && !em[0];
                    cpu_mask = em[0];
                    case (g)
                        0: begin irq_lines = 16'(1) << ln; irq_en = em[1] ? 16'(1) << ln : '0; end
                        1: begin key_lines = 16'(1) << ln; key_en = em[1] ? 16'(1) << ln : '0; end
                        2: begin wue_lines = 8'(1) << ln;  wue_en = em[1] ? 8'(1) << ln : '0; end
                        default: begin wdt_ovf = 1'b1; wdt_ovf_ie = em[1]; end
                    endcase
                    nx();
                    check_mode("R4 qualified wake", woke ? 2 : 4);
                    irq_lines = '0; irq_en = '0; key_lines = '0; key_en = '0;
                    wue_lines = '0; wue_en = '0; wdt_ovf = 1'b0; wdt_ovf_ie = 1'b0;
                    cpu_mask = 1'b0;
                    if (!woke) nmi_pulse();
                end
            end
        end

        // R4 NMI ignores mask
        go_watch(1'b1, 1'b0);
        cpu_mask = 1'b1;
        nmi_pulse();
        cpu_mask = 1'b0;
        check_mode("R4 nmi wakes when masked", 2);

        // R10 request inside watch mode is ignored
        go_watch(1'b1, 1'b0);
        cfg_direct_xfer = 1'b1;
        sleep_req = 1'b1;
        nx();
        sleep_req = 1'b0;
        check_mode("R10 watch ignores sleep_req", 4);
        cfg_good();
        nmi_pulse();

        // R6 settling length sweep with both destinations
        for (int dv = 0; dv < 2; dv++) begin
            for (int s = 0; s < 8; s++) begin
                cfg_settle_sel = SELW'(s);
                go_watch(1'b0, dv[0]);
                nmi_pulse();
                check(irq_start == 1'b0, "R6 no early irq_start", 32'(irq_start), 0);
                count_in(5, cnt);
                check(cnt == (1 << (BASE + s)), "R6 settle length", 32'(cnt), 32'(1 << (BASE + s)));
                check_mode("R6 destination", dv ? 1 : 0);
                check(irq_start, "R6 irq_start", 32'(irq_start), 1);
                nx();
                check(!irq_start, "R6 irq_start one cycle", 32'(irq_start), 0);
            end
        end

        // R8 reset pin held long, then short
        cfg_settle_sel = '0;
        go_watch(1'b0, 1'b0);
        pin_reset_n = 1'b0;
        nx();
        check_mode("R8 reset-hold from watch", 6);
        check_clk("R8 clocks on", 3'b111);
        repeat (8) nx();
        check_mode("R8 still holding", 6);
        pin_reset_n = 1'b1;
        nx();
        check_mode("R8 released to high", 0);
        check(rst_exc_start, "R8 rst_exc_start", 32'(rst_exc_start), 1);
        nx();
        check(!rst_exc_start, "R8 rst_exc_start one cycle", 32'(rst_exc_start), 0);
        cfg_settle_sel = 3'd3;
        pin_reset_n = 1'b0;
        nx();
        pin_reset_n = 1'b1;
        count_in(6, cnt);
        check(cnt == 32, "R8 minimum hold", 32'(cnt), 32);
        check(rst_exc_start, "R8 rst_exc after short pulse", 32'(rst_exc_start), 1);

        // R9 standby pin from subactive and from settling
        go_watch(1'b1, 1'b0);
        nmi_pulse();
        pin_standby_n = 1'b0;
        pin_reset_n = 1'b0;
        nx();
        check_mode("R9 standby over reset", 7);
        check_clk("R9 standby clocks off", 3'b000);
        pin_reset_n = 1'b1;
        nmi = 1'b1;
        repeat (4) nx();
        nmi = 1'b0;
        check_mode("R9 standby ignores wake", 7);
        pin_standby_n = 1'b1;
        nx();
        check_mode("R9 release to reset-hold", 6);
        count_in(6, cnt);
        check(cnt == 32, "R9 reset-hold length", 32'(cnt), 32);
        check(rst_exc_start, "R9 rst_exc_start", 32'(rst_exc_start), 1);
        go_watch(1'b0, 1'b0);
        nmi_pulse();
        pin_standby_n = 1'b0;
        nx();
        pin_standby_n = 1'b1;
        check_mode("R9 standby from settling", 7);
        nx();
        check_mode("R9 reset-hold after settling", 6);

        done = 1;
        summary();
        $finish;
    end

endmodule